// File: doc/BRIEF.md
# PWM Brake Request Combiner

This block merges the fault signals around a PWM output stage into two brake requests. The fault signals are two analog comparator outputs, two brake pins, a system-fail summary and software strobes. The system-fail summary is an OR of four fail conditions, and each condition can be masked on its own. Each brake pin is picked from this module's own pin or the neighbouring module's pin, and then passes through a sampling debounce.

There are two brake paths over the same five sources, and each path has its own enable bits. The edge path latches a brake on a rising edge of any enabled source. It holds that brake until software writes a clear strobe, and it records which sources caused it. The level path follows the enabled sources and drops one clock after they all go low. Every asynchronous input passes through a two-flop synchronizer first.

Top module: `pwm_brake_agg`

## Requirements
- R1: `sysfail_o` is the OR of `fail_i & fail_en_i`, where bit 0 is clock failure, bit 1 is brown-out, bit 2 is parity error and bit 3 is lockup. It follows a change of `fail_i` after two clock edges.
- R2: `brk_en_i` edge-path enables are bit 0 for comparator 0, bit 1 for comparator 1, bit 4 for pin 0, bit 5 for pin 1 and bit 7 for system fail. A rising edge of an enabled comparator or fail input sets `edge_brk_o` on the third clock edge.
- R3: `brk_en_i` level-path enables are bit 8 for comparator 0, bit 9 for comparator 1, bit 12 for pin 0, bit 13 for pin 1 and bit 15 for system fail. `level_brk_o` is high while any enabled level source is high. It goes low on the third edge after a comparator or fail input falls, which is one clock after the synchronized sources are all low.
- R4: `edge_brk_o` stays set until `edge_clr_i` is pulsed, and it is low after the next edge. A new set in the same cycle as a clear wins.
- R5: Clearing an enable bit does not clear a latched edge brake. Setting an enable while its source is already high does not latch, because only rising edges count.
- R6: For pin n, `pin_sel_i[n]`=0 selects `pin_own_i[n]` and 1 selects `pin_peer_i[n]`. The unselected pin has no effect.
- R7: The pin filter samples once every `filt_div_i`+1 clocks. Its output `pin_filt_o` changes only on the third equal sample in a row, so with a divider of 0 it changes five edges after the pin. A pulse that lasts for two samples is ignored.
- R8: `sw_edge_i` sets `edge_brk_o` on the next edge. `sw_level_i` drives `level_brk_o` high on the next edge, for as long as the strobe is held.
- R9: `edge_cause_o` holds a sticky flag for each enabled source that produced an edge. Bit 0 is comparator 0, bit 1 is comparator 1, bit 2 is pin 0, bit 3 is pin 1 and bit 4 is system fail. The flags are cleared by `edge_clr_i`.
- R10: During reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| cmp_i | input | 2 | comparator outputs (async) |
| pin_own_i | input | 2 | this module's brake pins (async) |
| pin_peer_i | input | 2 | neighbour's brake pins (async) |
| pin_sel_i | input | 2 | per-pin source select |
| fail_i | input | 4 | system-fail conditions (async) |
| fail_en_i | input | 4 | fail-condition enables |
| brk_en_i | input | 16 | edge/level source enables |
| filt_div_i | input | DIV_W | filter sample divider |
| sw_edge_i | input | 1 | software edge brake strobe |
| sw_level_i | input | 1 | software level brake strobe |
| edge_clr_i | input | 1 | clear latched edge brake |
| edge_brk_o | output | 1 | latched edge brake request |
| level_brk_o | output | 1 | level brake request |
| edge_cause_o | output | 5 | sticky edge cause flags |
| sysfail_o | output | 1 | masked system-fail summary |
| pin_filt_o | output | 2 | filtered brake pins |

## Verification
A wrong synchronizer or edge register shows up as `edge_brk_o` rising one cycle early or one cycle late, or not rising at all. A corrupt filter history shows up as `pin_filt_o` changing after fewer than three samples, or as a two-sample glitch getting through to `level_brk_o` within about five clocks. A latch that loses state, or a wrong enable bit position, shows up at once as a missing or extra brake or cause flag. Random stimulus that is held steady exposes a wrong gating term in the level or fail OR within eight clocks.

// File: rtl/brk_pkg.sv
package brk_pkg;
  localparam int NSRC = 5;
  typedef logic [NSRC-1:0] src_vec_t;

  // source order: 0 cmp0, 1 cmp1, 2 pin0, 3 pin1, 4 system fail
  function automatic src_vec_t edge_mask(input logic [15:0] en);
    return {en[7], en[5], en[4], en[1], en[0]};
  endfunction

  function automatic src_vec_t level_mask(input logic [15:0] en);
    return {en[15], en[13], en[12], en[9], en[8]};
  endfunction

  function automatic logic fail_or(input logic [3:0] cond, input logic [3:0] en);
    return |(cond & en);
  endfunction
endpackage

// File: rtl/brk_sync.sv
module brk_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q_o  <= '0;
    end else begin
      meta <= d_i;
      q_o  <= meta;
    end
  end
endmodule

// File: rtl/brk_pin_filter.sv
module brk_pin_filter (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic pin_i,
  output logic filt_o
);
  logic [1:0] hist;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist   <= '0;
      filt_o <= 1'b0;
    end else if (tick_i) begin
      hist <= {hist[0], pin_i};
      if (hist == {pin_i, pin_i}) filt_o <= pin_i;
    end
  end

  // R7: output moves only on a sample tick
  p_filt_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_o != $past(filt_o)) |-> $past(tick_i));
  // R7: a new output value was seen on the two previous samples
  p_filt_history_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(filt_o) |-> hist[0]);
endmodule

// File: rtl/pwm_brake_agg.sv
module pwm_brake_agg
  import brk_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cmp_i,
  input  logic [1:0]       pin_own_i,
  input  logic [1:0]       pin_peer_i,
  input  logic [1:0]       pin_sel_i,
  input  logic [3:0]       fail_i,
  input  logic [3:0]       fail_en_i,
  input  logic [15:0]      brk_en_i,
  input  logic [DIV_W-1:0] filt_div_i,
  input  logic             sw_edge_i,
  input  logic             sw_level_i,
  input  logic             edge_clr_i,
  output logic             edge_brk_o,
  output logic             level_brk_o,
  output logic [NSRC-1:0]  edge_cause_o,
  output logic             sysfail_o,
  output logic [1:0]       pin_filt_o
);
  localparam int NPIN = 2;
  localparam int SYNC_W = 2 + NPIN + 4;

  logic [NPIN-1:0]  pin_raw;
  logic [1:0]       cmp_s;
  logic [NPIN-1:0]  pin_s;
  logic [3:0]       fail_s;
  logic [DIV_W-1:0] div_cnt;
  logic             samp_tick;
  src_vec_t         src, src_d, rise, lvl_act;
  logic             edge_set;

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    assign pin_raw[i] = pin_sel_i[i] ? pin_peer_i[i] : pin_own_i[i];
    brk_pin_filter u_filt (
      .clk(clk), .rst_n(rst_n), .tick_i(samp_tick),
      .pin_i(pin_s[i]), .filt_o(pin_filt_o[i])
    );
  end

  brk_sync #(.W(SYNC_W)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_i({fail_i, pin_raw, cmp_i}),
    .q_o({fail_s, pin_s, cmp_s})
  );

  assign samp_tick = (div_cnt >= filt_div_i);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_cnt <= '0;
    else        div_cnt <= samp_tick ? '0 : div_cnt + 1'b1;
  end

  assign sysfail_o = fail_or(fail_s, fail_en_i);
  assign src       = {sysfail_o, pin_filt_o, cmp_s};
  assign rise      = src & ~src_d & edge_mask(brk_en_i);
  assign lvl_act   = src & level_mask(brk_en_i);
  assign edge_set  = (|rise) | sw_edge_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_d        <= '0;
      edge_brk_o   <= 1'b0;
      edge_cause_o <= '0;
      level_brk_o  <= 1'b0;
    end else begin
      src_d       <= src;
      level_brk_o <= (|lvl_act) | sw_level_i;
      if (edge_set)        edge_brk_o <= 1'b1;
      else if (edge_clr_i) edge_brk_o <= 1'b0;
      edge_cause_o <= edge_clr_i ? rise : (edge_cause_o | rise);
    end
  end

  // R4: a latched brake survives unless cleared
  p_edge_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_brk_o && !edge_clr_i) |=> edge_brk_o);
  // R4: clear without a new set drops the brake
  p_edge_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_clr_i && !edge_set) |=> !edge_brk_o);
  // R8: software edge strobe always latches
  p_sw_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sw_edge_i |=> edge_brk_o);
  // R3: no active level source means no level brake next cycle
  p_level_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_act == '0 && !sw_level_i) |=> !level_brk_o);
  // R9: any cause flag implies a latched brake
  p_cause_implies_brk_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_cause_o != '0) |-> edge_brk_o);
endmodule

// File: tb/pwm_brake_agg_test.sv
module pwm_brake_agg_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cmp = '0, own = '0, peer = '0, sel = '0;
  logic [3:0] fail = '0, fail_en = '0;
  logic [15:0] en = '0;
  logic [7:0] div = '0;
  logic sw_e = 1'b0, sw_l = 1'b0, clr = 1'b0;
  logic edge_brk, level_brk, sysfail;
  logic [4:0] cause;
  logic [1:0] pfilt;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk; // 50 MHz

  pwm_brake_agg #(.DIV_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .cmp_i(cmp), .pin_own_i(own), .pin_peer_i(peer),
    .pin_sel_i(sel), .fail_i(fail), .fail_en_i(fail_en), .brk_en_i(en),
    .filt_div_i(div), .sw_edge_i(sw_e), .sw_level_i(sw_l), .edge_clr_i(clr),
    .edge_brk_o(edge_brk), .level_brk_o(level_brk), .edge_cause_o(cause),
    .sysfail_o(sysfail), .pin_filt_o(pfilt)
  );

  task automatic wait_edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic m_sys(input logic [3:0] f, input logic [3:0] m);
    logic r = 1'b0;
    for (int k = 0; k < 4; k++) if (f[k] && m[k]) r = 1'b1;
    return r;
  endfunction

  function automatic logic m_level(input logic [1:0] c, input logic [1:0] p,
                                   input logic s, input logic [15:0] e);
    return (c[0] & e[8]) | (c[1] & e[9]) | (p[0] & e[12]) | (p[1] & e[13]) | (s & e[15]);
  endfunction

  function automatic logic [1:0] m_pin(input logic [1:0] o, input logic [1:0] q,
                                       input logic [1:0] s);
    return {s[1] ? q[1] : o[1], s[0] ? q[0] : o[0]};
  endfunction

  initial begin
    #4_000_000;
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    wait_edges(2);
    // R10 reset state
    check("R10", {edge_brk, level_brk, cause, sysfail, pfilt}, '0);
    rst_n = 1'b1;
    wait_edges(2);

    // R1 masked fail OR
    fail_en = 4'b0100; fail = 4'b0001;
    wait_edges(3);
    check("R1 masked", sysfail, 1'b0);
    fail = 4'b0100;
    wait_edges(1);
    check("R1 latency", sysfail, 1'b0);
    wait_edges(1);
    check("R1 parity", sysfail, 1'b1);
    fail = '0; wait_edges(3);

    // R2 edge on cmp0
    en = 16'h0001; cmp = 2'b01;
    wait_edges(2);
    check("R2 early", edge_brk, 1'b0);
    wait_edges(1);
    check("R2 set", edge_brk, 1'b1);
    check("R9 cause cmp0", cause, 5'b00001);
    cmp = 2'b00; wait_edges(4);
    check("R4 hold", edge_brk, 1'b1);
    clr = 1'b1; wait_edges(1); clr = 1'b0;
    check("R4 clear", edge_brk, 1'b0);
    check("R9 cleared", cause, 5'b0);

    // R5 enable while high does not latch; disable keeps latch
    en = 16'h0000; cmp = 2'b10; wait_edges(4);
    en = 16'h0002; wait_edges(4);
    check("R5 no latch", edge_brk, 1'b0);
    cmp = 2'b00; wait_edges(3);
    cmp = 2'b10; wait_edges(3);
    check("R5 latch cmp1", cause, 5'b00010);
    en = 16'h0000; wait_edges(3);
    check("R5 kept", edge_brk, 1'b1);
    cmp = 2'b00; clr = 1'b1; wait_edges(1); clr = 1'b0;

    // R3 level path on cmp1
    en = 16'h0200; cmp = 2'b10;
    wait_edges(3);
    check("R3 rise", level_brk, 1'b1);
    cmp = 2'b00;
    wait_edges(2);
    check("R3 still", level_brk, 1'b1);
    wait_edges(1);
    check("R3 fall", level_brk, 1'b0);

    // R6/R7 pin select and filter timing (divider 0)
    en = 16'h1010; sel = 2'b01; own = 2'b01; wait_edges(8);
    check("R6 own ignored", {pfilt, level_brk}, 3'b000);
    peer = 2'b01;
    wait_edges(4);
    check("R7 not yet", pfilt, 2'b00);
    wait_edges(1);
    check("R7 filt", pfilt, 2'b01);
    wait_edges(1);
    check("R6 peer level", level_brk, 1'b1);
    check("R2 pin0 edge", cause, 5'b00100);
    peer = 2'b00; own = 2'b00; clr = 1'b1; wait_edges(1); clr = 1'b0;
    wait_edges(8);
    // R7 two-sample glitch ignored
    sel = 2'b00; en = 16'h2020; own = 2'b10;
    wait_edges(2) ; own = 2'b00; @(posedge clk); @(negedge clk);
    wait_edges(6);
    check("R7 glitch", {pfilt, level_brk, edge_brk}, 4'b0000);
    // R7 divider 3
    div = 8'd3; own = 2'b10;
    wait_edges(6);
    check("R7 slow", pfilt, 2'b00);
    wait_edges(20);
    check("R7 slow done", pfilt, 2'b10);
    own = 2'b00; wait_edges(24); div = 8'd0;
    clr = 1'b1; wait_edges(1); clr = 1'b0;

    // R8 software strobes
    en = '0;
    sw_e = 1'b1; wait_edges(1); sw_e = 1'b0;
    check("R8 sw edge", edge_brk, 1'b1);
    clr = 1'b1; wait_edges(1); clr = 1'b0;
    sw_l = 1'b1; wait_edges(1); sw_l = 1'b0;
    check("R8 sw level on", level_brk, 1'b1);
    wait_edges(1);
    check("R8 sw level off", level_brk, 1'b0);

    // R4 set wins over clear; R9 system fail cause
    en = 16'h0080; fail_en = 4'hF; fail = 4'b1000;
    wait_edges(2);
    clr = 1'b1; wait_edges(1); clr = 1'b0;
    check("R4 set wins", edge_brk, 1'b1);
    check("R9 sys cause", cause, 5'b10000);
    fail = '0; wait_edges(3);
    clr = 1'b1; wait_edges(1); clr = 1'b0;

    // random steady patterns: R1 R3 R6 R7
    for (int it = 0; it < 300; it++) begin
      cmp = 2'($urandom); own = 2'($urandom); peer = 2'($urandom);
      sel = 2'($urandom); fail = 4'($urandom); fail_en = 4'($urandom);
      en = 16'($urandom) & 16'hB300;
      wait_edges(8);
      check("R3 random level", level_brk,
            m_level(cmp, m_pin(own, peer, sel), m_sys(fail, fail_en), en));
      check("R1 random sys", sysfail, m_sys(fail, fail_en));
      check("R6 random pin", pfilt, m_pin(own, peer, sel));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule